// File: doc/BRIEF.md
# Dirty Line Eviction Controller

This block manages the eviction of one line at a time from a shared cache toward memory. A clean line (exclusive or shared) is dropped silently, and the cache only sees an invalidate strobe. A dirty line (modified or owned) is copied into a one-entry transaction buffer. The block then sends a dirty-victim request to the directory, invalidates the line in the array, and holds the data until memory acknowledges the writeback. On that acknowledgement the buffered data goes out.

While an eviction is outstanding, other traffic to the same address can race it: directory probes, new victim writebacks from a core, core cancels of those writebacks, and reads. The controller resolves each of these with a small set of transient states. An invalidating probe that wins the race cancels the memory writeback. A core victim that arrives during the wait is acknowledged and its data is either dropped or merged, depending on the order in which the memory acknowledgement and the core data arrive. Reads to the evicting address go on to memory. Each input event is a single-cycle strobe, and at most one event is presented per cycle. Every response is a registered single-cycle strobe.

Top module: `dirty_evict_ctrl`

## Requirements
- R1: A replace strobe for a line in state shared (code 1) or exclusive (code 2) raises only `line_inval_o`. No directory request is made and the block stays idle.
- R2: A replace strobe for a line in state owned (code 3) or modified (code 4) raises `line_inval_o` and a directory request of kind victim (code 0) with the replace address. It also captures the line data, and the block waits for the memory acknowledgement.
- R3: A replace strobe is answered with `repl_retry_o` and has no other effect in two cases: the line is flagged as held by a victim transaction, or an eviction is already outstanding. Only one eviction is outstanding at a time.
- R4: While waiting, a memory acknowledgement sends the buffered data on the writeback port with dirty set and with the shared flag, then returns the block to idle.
- R5: While waiting, an invalidate probe (kind 0) is answered with response kind invalidate-ack (1), and an invalidate-with-data probe (kind 1) is answered with response kind data (2) carrying the buffered data. Both also issue a directory request of kind cancel (1), and the block then waits only for the memory acknowledgement.
- R6: While waiting, a downgrade probe (kind 2) is answered with buffered data (response kind 2). The wait continues, and the shared flag is set on the later writeback.
- R7: After a cancel, probes are answered with response kind miss (0) and core victims with `vic_retry_o`. The memory acknowledgement returns the block to idle with no writeback.
- R8: While waiting, a core victim to the address is acknowledged to its source. Core data that arrives before the memory acknowledgement is dropped with an unblock, and waiting resumes. A memory acknowledgement that arrives first sends the old buffered data.
- R9: After that early acknowledgement, a core victim is retried, and the later core data is discarded with an unblock before the block returns to idle.
- R10: With a core victim pending, an invalidating probe is answered from the buffer without a cancel. After that, probes answer miss. The memory acknowledgement then leads to a state where the next core data is written out with its dirty bit and an unblock, and the block goes idle.
- R11: A read to the evicting address produces a directory request of kind read (2) with that address. Reads to any other address are ignored.
- R12: In the core-victim wait, a cancel from the recorded source gives an unblock and returns to the plain wait. A cancel from another source is answered with `ccl_retry_o`.
- R13: Probes, victims, cancels and reads to other addresses, and acknowledgements or core data with no transaction to match, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| repl_valid_i | input | 1 | Replace strobe |
| repl_held_i | input | 1 | Line is held by a victim transaction |
| repl_addr_i | input | ADDR_W | Line address to replace |
| repl_state_i | input | 3 | Line state: 0 invalid, 1 shared, 2 exclusive, 3 owned, 4 modified |
| repl_data_i | input | DATA_W | Line data |
| mem_ack_i | input | 1 | Writeback acknowledgement from memory |
| prb_valid_i | input | 1 | Probe strobe |
| prb_kind_i | input | 2 | 0 invalidate, 1 invalidate with data, 2 downgrade |
| prb_addr_i | input | ADDR_W | Probe address |
| vic_valid_i | input | 1 | Core victim writeback request |
| vic_src_i | input | ID_W | Requesting core |
| vic_addr_i | input | ADDR_W | Victim address |
| cdata_valid_i | input | 1 | Core writeback data strobe |
| cdata_dirty_i | input | 1 | Core data dirty bit |
| cdata_i | input | DATA_W | Core writeback data |
| ccl_valid_i | input | 1 | Core writeback cancel |
| ccl_src_i | input | ID_W | Cancelling core |
| ccl_addr_i | input | ADDR_W | Cancel address |
| rd_valid_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| repl_retry_o | output | 1 | Replace must be retried |
| line_inval_o | output | 1 | Invalidate the line in the array |
| dreq_valid_o | output | 1 | Directory request strobe |
| dreq_kind_o | output | 2 | 0 victim, 1 cancel, 2 read |
| dreq_addr_o | output | ADDR_W | Directory request address |
| wb_valid_o | output | 1 | Writeback data strobe |
| wb_data_o | output | DATA_W | Writeback data |
| wb_dirty_o | output | 1 | Writeback dirty bit |
| wb_shared_o | output | 1 | Writeback shared flag |
| prsp_valid_o | output | 1 | Probe response strobe |
| prsp_kind_o | output | 2 | 0 miss, 1 invalidate-ack, 2 data |
| prsp_data_o | output | DATA_W | Probe response data |
| vic_ack_o | output | 1 | Core victim acknowledged |
| vic_retry_o | output | 1 | Core victim must be retried |
| vic_dst_o | output | ID_W | Core that the victim acknowledgement goes to |
| unblk_o | output | 1 | Unblock to the directory |
| ccl_retry_o | output | 1 | Core cancel must be retried |

## Verification
Every result passes through exactly one register, so the response to an event is due one clock edge after the edge that samples it, and it lasts that one cycle only. The bench drives each event on a falling edge, removes it at the next falling edge, and compares every output there in the same step. A missing strobe, an extra strobe and a late strobe are therefore all caught by the one comparison. Silent cases are checked the same way at the same position, where every output must be low.

// File: rtl/evict_pkg.sv
package evict_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHR = 3'd1,
    LS_EXC = 3'd2,
    LS_OWN = 3'd3,
    LS_MOD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    PRB_INV      = 2'd0,
    PRB_INV_DATA = 2'd1,
    PRB_DOWN     = 2'd2
  } prb_kind_e;

  typedef enum logic [1:0] {
    PRSP_MISS    = 2'd0,
    PRSP_INV_ACK = 2'd1,
    PRSP_DATA    = 2'd2
  } prsp_kind_e;

  typedef enum logic [1:0] {
    DREQ_VICTIM = 2'd0,
    DREQ_CANCEL = 2'd1,
    DREQ_READ   = 2'd2
  } dreq_kind_e;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_WAIT_ACK,   // buffered dirty data, waiting for memory ack
    EV_WAIT_VIC,   // as above, plus a core victim in flight
    EV_DROP,       // ack done, core data still owed, will be dropped
    EV_PRB_VIC,    // probed while core victim in flight
    EV_NEED_DATA,  // ack done after probe, core data goes to memory
    EV_CANCELLED   // memory writeback cancelled, waiting for its ack
  } ev_st_e;

  typedef struct packed {
    logic       inval;
    logic       repl_retry;
    logic       dreq;
    dreq_kind_e dreq_kind;
    logic       wb;
    logic       wb_core;
    logic       prsp;
    prsp_kind_e prsp_kind;
    logic       set_shared;
    logic       vic_ack;
    logic       vic_retry;
    logic       set_from;
    logic       unblk;
    logic       ccl_retry;
    logic       buf_load;
    logic       core_wr;
  } act_t;

endpackage

// File: rtl/evict_buf.sv
module evict_buf
  import evict_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shared_set_i,
  input  logic              from_set_i,
  input  logic [ID_W-1:0]   from_i,
  input  logic              core_wr_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic              core_dirty_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              dirty_o,
  output logic              shared_o,
  output logic [ID_W-1:0]   from_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      data_o   <= '0;
      dirty_o  <= 1'b0;
      shared_o <= 1'b0;
      from_o   <= '0;
    end else begin
      if (load_i) begin
        addr_o   <= load_addr_i;
        data_o   <= load_data_i;
        dirty_o  <= 1'b1;
        shared_o <= 1'b0;
      end else if (core_wr_i) begin
        data_o  <= core_data_i;
        dirty_o <= core_dirty_i;
      end
      if (shared_set_i) shared_o <= 1'b1;
      if (from_set_i)   from_o   <= from_i;
    end
  end

  AST_LOAD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && (core_wr_i || shared_set_i))); // R2

endmodule

// File: rtl/evict_fsm.sv
module evict_fsm
  import evict_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      repl_valid_i,
  input  logic      repl_held_i,
  input  line_st_e  repl_state_i,
  input  logic      mem_ack_i,
  input  logic      prb_hit_i,
  input  prb_kind_e prb_kind_i,
  input  logic      vic_hit_i,
  input  logic      cdata_valid_i,
  input  logic      ccl_hit_i,
  input  logic      ccl_own_i,
  input  logic      rd_hit_i,
  output act_t      act_o,
  output ev_st_e    state_o
);

  ev_st_e st_q, st_d;
  act_t   act;

  always_comb begin
    act  = '0;
    st_d = st_q;

    if (repl_valid_i) begin
      if (st_q != EV_IDLE || repl_held_i) begin
        act.repl_retry = 1'b1;
      end else if (repl_state_i == LS_MOD || repl_state_i == LS_OWN) begin
        act.inval     = 1'b1;
        act.dreq      = 1'b1;
        act.dreq_kind = DREQ_VICTIM;
        act.buf_load  = 1'b1;
        st_d          = EV_WAIT_ACK;
      end else if (repl_state_i == LS_SHR || repl_state_i == LS_EXC) begin
        act.inval = 1'b1;
      end
    end

    if (rd_hit_i) begin
      act.dreq      = 1'b1;
      act.dreq_kind = DREQ_READ;
    end

    if (vic_hit_i) begin
      if (st_q == EV_WAIT_ACK) begin
        act.vic_ack  = 1'b1;
        act.set_from = 1'b1;
        st_d         = EV_WAIT_VIC;
      end else begin
        act.vic_retry = 1'b1;
      end
    end

    if (prb_hit_i) begin
      act.prsp = 1'b1;
      if (st_q == EV_WAIT_ACK || st_q == EV_WAIT_VIC) begin
        if (prb_kind_i == PRB_DOWN) begin
          act.prsp_kind  = PRSP_DATA;
          act.set_shared = 1'b1;
        end else begin
          act.prsp_kind = (prb_kind_i == PRB_INV_DATA) ? PRSP_DATA : PRSP_INV_ACK;
          if (st_q == EV_WAIT_ACK) begin
            act.dreq      = 1'b1;
            act.dreq_kind = DREQ_CANCEL;
            st_d          = EV_CANCELLED;
          end else begin
            st_d = EV_PRB_VIC;
          end
        end
      end else begin
        act.prsp_kind = PRSP_MISS;
      end
    end

    if (ccl_hit_i) begin
      if ((st_q == EV_WAIT_VIC || st_q == EV_DROP) && ccl_own_i) begin
        act.unblk = 1'b1;
        st_d      = (st_q == EV_WAIT_VIC) ? EV_WAIT_ACK : EV_IDLE;
      end else begin
        act.ccl_retry = 1'b1;
      end
    end

    if (mem_ack_i) begin
      case (st_q)
        EV_WAIT_ACK:  begin act.wb = 1'b1; st_d = EV_IDLE; end
        EV_WAIT_VIC:  begin act.wb = 1'b1; st_d = EV_DROP; end
        EV_PRB_VIC:   st_d = EV_NEED_DATA;
        EV_CANCELLED: st_d = EV_IDLE;
        default: ;
      endcase
    end

    if (cdata_valid_i) begin
      case (st_q)
        EV_WAIT_VIC: begin act.unblk = 1'b1; st_d = EV_WAIT_ACK; end
        EV_DROP:     begin act.unblk = 1'b1; st_d = EV_IDLE; end
        EV_PRB_VIC: begin
          act.core_wr = 1'b1;
          act.unblk   = 1'b1;
          st_d        = EV_WAIT_ACK;
        end
        EV_NEED_DATA: begin
          act.core_wr = 1'b1;
          act.wb      = 1'b1;
          act.wb_core = 1'b1;
          act.unblk   = 1'b1;
          st_d        = EV_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= EV_IDLE;
    else         st_q <= st_d;
  end

  assign act_o   = act;
  assign state_o = st_q;

  AST_NO_BUSY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act.buf_load |-> st_q == EV_IDLE); // R3
  AST_CANCEL_ONLY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == EV_CANCELLED && $past(st_q) != EV_CANCELLED) |-> $past(st_q) == EV_WAIT_ACK); // R5

endmodule

// File: rtl/dirty_evict_ctrl.sv
module dirty_evict_ctrl
  import evict_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              repl_valid_i,
  input  logic              repl_held_i,
  input  logic [ADDR_W-1:0] repl_addr_i,
  input  logic [2:0]        repl_state_i,
  input  logic [DATA_W-1:0] repl_data_i,
  input  logic              mem_ack_i,
  input  logic              prb_valid_i,
  input  logic [1:0]        prb_kind_i,
  input  logic [ADDR_W-1:0] prb_addr_i,
  input  logic              vic_valid_i,
  input  logic [ID_W-1:0]   vic_src_i,
  input  logic [ADDR_W-1:0] vic_addr_i,
  input  logic              cdata_valid_i,
  input  logic              cdata_dirty_i,
  input  logic [DATA_W-1:0] cdata_i,
  input  logic              ccl_valid_i,
  input  logic [ID_W-1:0]   ccl_src_i,
  input  logic [ADDR_W-1:0] ccl_addr_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              repl_retry_o,
  output logic              line_inval_o,
  output logic              dreq_valid_o,
  output logic [1:0]        dreq_kind_o,
  output logic [ADDR_W-1:0] dreq_addr_o,
  output logic              wb_valid_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_dirty_o,
  output logic              wb_shared_o,
  output logic              prsp_valid_o,
  output logic [1:0]        prsp_kind_o,
  output logic [DATA_W-1:0] prsp_data_o,
  output logic              vic_ack_o,
  output logic              vic_retry_o,
  output logic [ID_W-1:0]   vic_dst_o,
  output logic              unblk_o,
  output logic              ccl_retry_o
);

  localparam int N_CMP = 4;  // probe, victim, cancel, read
  localparam int C_PRB = 0;
  localparam int C_VIC = 1;
  localparam int C_CCL = 2;
  localparam int C_RD  = 3;

  act_t              act;
  ev_st_e            st;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic              buf_dirty, buf_shared;
  logic [ID_W-1:0]   buf_from;
  logic              busy;

  logic [N_CMP-1:0][ADDR_W-1:0] cmp_addr;
  logic [N_CMP-1:0]             cmp_hit;

  assign busy     = (st != EV_IDLE);
  assign cmp_addr = {rd_addr_i, ccl_addr_i, vic_addr_i, prb_addr_i};

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign cmp_hit[g] = busy && (cmp_addr[g] == buf_addr);
  end

  evict_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .repl_valid_i  (repl_valid_i),
    .repl_held_i   (repl_held_i),
    .repl_state_i  (line_st_e'(repl_state_i)),
    .mem_ack_i     (mem_ack_i),
    .prb_hit_i     (prb_valid_i && cmp_hit[C_PRB]),
    .prb_kind_i    (prb_kind_e'(prb_kind_i)),
    .vic_hit_i     (vic_valid_i && cmp_hit[C_VIC]),
    .cdata_valid_i (cdata_valid_i),
    .ccl_hit_i     (ccl_valid_i && cmp_hit[C_CCL]),
    .ccl_own_i     (ccl_src_i == buf_from),
    .rd_hit_i      (rd_valid_i && cmp_hit[C_RD]),
    .act_o         (act),
    .state_o       (st)
  );

  evict_buf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
  ) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (act.buf_load),
    .load_addr_i  (repl_addr_i),
    .load_data_i  (repl_data_i),
    .shared_set_i (act.set_shared),
    .from_set_i   (act.set_from),
    .from_i       (vic_src_i),
    .core_wr_i    (act.core_wr),
    .core_data_i  (cdata_i),
    .core_dirty_i (cdata_dirty_i),
    .addr_o       (buf_addr),
    .data_o       (buf_data),
    .dirty_o      (buf_dirty),
    .shared_o     (buf_shared),
    .from_o       (buf_from)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      repl_retry_o <= 1'b0;
      line_inval_o <= 1'b0;
      dreq_valid_o <= 1'b0;
      dreq_kind_o  <= '0;
      dreq_addr_o  <= '0;
      wb_valid_o   <= 1'b0;
      wb_data_o    <= '0;
      wb_dirty_o   <= 1'b0;
      wb_shared_o  <= 1'b0;
      prsp_valid_o <= 1'b0;
      prsp_kind_o  <= '0;
      prsp_data_o  <= '0;
      vic_ack_o    <= 1'b0;
      vic_retry_o  <= 1'b0;
      vic_dst_o    <= '0;
      unblk_o      <= 1'b0;
      ccl_retry_o  <= 1'b0;
    end else begin
      repl_retry_o <= act.repl_retry;
      line_inval_o <= act.inval;
      dreq_valid_o <= act.dreq;
      dreq_kind_o  <= act.dreq_kind;
      dreq_addr_o  <= act.buf_load ? repl_addr_i : buf_addr;
      wb_valid_o   <= act.wb;
      wb_data_o    <= act.wb_core ? cdata_i : buf_data;
      wb_dirty_o   <= act.wb_core ? cdata_dirty_i : buf_dirty;
      wb_shared_o  <= act.wb && buf_shared;
      prsp_valid_o <= act.prsp;
      prsp_kind_o  <= act.prsp_kind;
      prsp_data_o  <= buf_data;
      vic_ack_o    <= act.vic_ack;
      vic_retry_o  <= act.vic_retry;
      vic_dst_o    <= vic_src_i;
      unblk_o      <= act.unblk;
      ccl_retry_o  <= act.ccl_retry;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({repl_valid_i, mem_ack_i, prb_valid_i, vic_valid_i,
                cdata_valid_i, ccl_valid_i, rd_valid_i}) <= 1); // R13
  AST_VICTIM_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_valid_o && dreq_kind_o == DREQ_VICTIM) |-> $past(st) == EV_IDLE); // R3
  AST_CANCEL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_valid_o && dreq_kind_o == DREQ_CANCEL) |-> st == EV_CANCELLED); // R5
  AST_CANCELLED_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prsp_valid_o && st == EV_CANCELLED && $past(st) == EV_CANCELLED)
      |-> prsp_kind_o == PRSP_MISS); // R7
  AST_WB_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (st == EV_IDLE || st == EV_DROP)); // R4
  AST_ACK_RETRY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vic_ack_o && vic_retry_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == EV_IDLE && $past(st) == EV_IDLE)
      |-> !(wb_valid_o || prsp_valid_o || unblk_o || vic_ack_o || dreq_valid_o)); // R13

endmodule

// File: tb/dirty_evict_ctrl_test.sv
module dirty_evict_ctrl_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;

  // event codes
  localparam int E_NONE = 0, E_REPL = 1, E_ACK = 2, E_PRB = 3, E_VIC = 4,
                 E_CDAT = 5, E_CCL = 6, E_RD = 7, E_HELD = 8;
  localparam int A  = 'h0100;
  localparam int B  = 'h0200;
  localparam int D0 = 32'hCAFE0001;
  localparam int D1 = 32'h5555AAAA;
  localparam int D2 = 32'h0BAD0002;

  typedef struct packed {
    int ev; int arg; int addr; int data;
    int req; int rk; int wb; int shr; int dty; int prsp; int pk;
    int ack; int vrt; int unb; int rrt; int inv; int crt;
    int edata; int rid;
  } vec_t;

  localparam int NV = 40;
  // ev arg addr data | req rk wb shr dty prsp pk ack vrt unb rrt inv crt | edata rid
  localparam vec_t VECS [NV] = '{
    '{E_REPL,1,A,0,  0,0,0,0,0,0,0,0,0,0,0,1,0, 0, 1},  // R1 shared dropped
    '{E_REPL,2,A,0,  0,0,0,0,0,0,0,0,0,0,0,1,0, 0, 1},  // R1 exclusive dropped
    '{E_REPL,4,A,D0, 1,0,0,0,0,0,0,0,0,0,0,1,0, 0, 2},  // R2 modified evicted
    '{E_REPL,3,B,D2, 0,0,0,0,0,0,0,0,0,0,1,0,0, 0, 3},  // R3 busy retry
    '{E_PRB,0,B,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 13}, // R13 other address
    '{E_RD,0,A,0,    1,2,0,0,0,0,0,0,0,0,0,0,0, 0, 11}, // R11 forward
    '{E_RD,0,B,0,    0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 11}, // R11 ignored
    '{E_PRB,2,A,0,   0,0,0,0,0,1,2,0,0,0,0,0,0, D0,6},  // R6 downgrade
    '{E_ACK,0,0,0,   0,0,1,1,1,0,0,0,0,0,0,0,0, D0,4},  // R4 shared writeback
    '{E_ACK,0,0,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 13}, // R13 stray ack
    '{E_HELD,4,A,D0, 0,0,0,0,0,0,0,0,0,0,1,0,0, 0, 3},  // R3 held retry
    '{E_REPL,3,A,D2, 1,0,0,0,0,0,0,0,0,0,0,1,0, 0, 2},  // R2 owned evicted
    '{E_PRB,1,A,0,   1,1,0,0,0,1,2,0,0,0,0,0,0, D2,5},  // R5 inv-data cancel
    '{E_PRB,0,A,0,   0,0,0,0,0,1,0,0,0,0,0,0,0, 0, 7},  // R7 miss
    '{E_VIC,3,A,0,   0,0,0,0,0,0,0,0,1,0,0,0,0, 0, 7},  // R7 victim retry
    '{E_ACK,0,0,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 7},  // R7 silent ack
    '{E_REPL,4,A,D0, 1,0,0,0,0,0,0,0,0,0,0,1,0, 0, 2},  // R2
    '{E_PRB,0,A,0,   1,1,0,0,0,1,1,0,0,0,0,0,0, 0, 5},  // R5 inv cancel
    '{E_ACK,0,0,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 7},  // R7
    '{E_REPL,4,A,D0, 1,0,0,0,0,0,0,0,0,0,0,1,0, 0, 2},  // R2
    '{E_VIC,5,A,0,   0,0,0,0,0,0,0,1,0,0,0,0,0, 0, 8},  // R8 victim ack
    '{E_CCL,2,A,0,   0,0,0,0,0,0,0,0,0,0,0,0,1, 0, 12}, // R12 foreign cancel
    '{E_CCL,5,A,0,   0,0,0,0,0,0,0,0,0,1,0,0,0, 0, 12}, // R12 own cancel
    '{E_VIC,5,A,0,   0,0,0,0,0,0,0,1,0,0,0,0,0, 0, 8},  // R8
    '{E_CDAT,1,0,D1, 0,0,0,0,0,0,0,0,0,1,0,0,0, 0, 8},  // R8 core data dropped
    '{E_ACK,0,0,0,   0,0,1,0,1,0,0,0,0,0,0,0,0, D0,8},  // R8 old data out
    '{E_REPL,4,A,D2, 1,0,0,0,0,0,0,0,0,0,0,1,0, 0, 2},  // R2
    '{E_VIC,1,A,0,   0,0,0,0,0,0,0,1,0,0,0,0,0, 0, 8},  // R8
    '{E_ACK,0,0,0,   0,0,1,0,1,0,0,0,0,0,0,0,0, D2,8},  // R8 ack first
    '{E_VIC,4,A,0,   0,0,0,0,0,0,0,0,1,0,0,0,0, 0, 9},  // R9 retry
    '{E_CDAT,1,0,D1, 0,0,0,0,0,0,0,0,0,1,0,0,0, 0, 9},  // R9 discard
    '{E_ACK,0,0,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 9},  // R9 idle again
    '{E_REPL,4,A,D0, 1,0,0,0,0,0,0,0,0,0,0,1,0, 0, 2},  // R2
    '{E_VIC,1,A,0,   0,0,0,0,0,0,0,1,0,0,0,0,0, 0, 8},  // R8
    '{E_PRB,1,A,0,   0,0,0,0,0,1,2,0,0,0,0,0,0, D0,10}, // R10 no cancel
    '{E_PRB,2,A,0,   0,0,0,0,0,1,0,0,0,0,0,0,0, 0, 10}, // R10 miss
    '{E_ACK,0,0,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 10}, // R10
    '{E_CDAT,1,0,D1, 0,0,1,0,1,0,0,0,0,1,0,0,0, D1,10}, // R10 core data out
    '{E_ACK,0,0,0,   0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 10}, // R10 idle
    '{E_CDAT,1,0,D1, 0,0,0,0,0,0,0,0,0,0,0,0,0, 0, 13}  // R13 stray data
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic              repl_valid, repl_held, mem_ack, prb_valid, vic_valid;
  logic              cdata_valid, cdata_dirty, ccl_valid, rd_valid;
  logic [ADDR_W-1:0] repl_addr, prb_addr, vic_addr, ccl_addr, rd_addr;
  logic [2:0]        repl_state;
  logic [1:0]        prb_kind;
  logic [DATA_W-1:0] repl_data, cdata;
  logic [ID_W-1:0]   vic_src, ccl_src;

  logic              repl_retry, line_inval, dreq_valid, wb_valid, wb_dirty, wb_shared;
  logic              prsp_valid, vic_ack, vic_retry, unblk, ccl_retry;
  logic [1:0]        dreq_kind, prsp_kind;
  logic [ADDR_W-1:0] dreq_addr;
  logic [DATA_W-1:0] wb_data, prsp_data;
  logic [ID_W-1:0]   vic_dst;

  dirty_evict_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .repl_valid_i(repl_valid), .repl_held_i(repl_held), .repl_addr_i(repl_addr),
    .repl_state_i(repl_state), .repl_data_i(repl_data), .mem_ack_i(mem_ack),
    .prb_valid_i(prb_valid), .prb_kind_i(prb_kind), .prb_addr_i(prb_addr),
    .vic_valid_i(vic_valid), .vic_src_i(vic_src), .vic_addr_i(vic_addr),
    .cdata_valid_i(cdata_valid), .cdata_dirty_i(cdata_dirty), .cdata_i(cdata),
    .ccl_valid_i(ccl_valid), .ccl_src_i(ccl_src), .ccl_addr_i(ccl_addr),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .repl_retry_o(repl_retry), .line_inval_o(line_inval),
    .dreq_valid_o(dreq_valid), .dreq_kind_o(dreq_kind), .dreq_addr_o(dreq_addr),
    .wb_valid_o(wb_valid), .wb_data_o(wb_data), .wb_dirty_o(wb_dirty),
    .wb_shared_o(wb_shared), .prsp_valid_o(prsp_valid), .prsp_kind_o(prsp_kind),
    .prsp_data_o(prsp_data), .vic_ack_o(vic_ack), .vic_retry_o(vic_retry),
    .vic_dst_o(vic_dst), .unblk_o(unblk), .ccl_retry_o(ccl_retry)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic clear_in();
    repl_valid = 0; repl_held = 0; mem_ack = 0; prb_valid = 0; vic_valid = 0;
    cdata_valid = 0; cdata_dirty = 0; ccl_valid = 0; rd_valid = 0;
    repl_addr = '0; prb_addr = '0; vic_addr = '0; ccl_addr = '0; rd_addr = '0;
    repl_state = '0; prb_kind = '0; repl_data = '0; cdata = '0;
    vic_src = '0; ccl_src = '0;
  endtask

  task automatic drive(input vec_t v);
    clear_in();
    case (v.ev)
      E_REPL, E_HELD: begin
        repl_valid = 1; repl_held = (v.ev == E_HELD);
        repl_state = v.arg[2:0]; repl_addr = v.addr[ADDR_W-1:0];
        repl_data = v.data[DATA_W-1:0];
      end
      E_ACK:  mem_ack = 1;
      E_PRB:  begin prb_valid = 1; prb_kind = v.arg[1:0]; prb_addr = v.addr[ADDR_W-1:0]; end
      E_VIC:  begin vic_valid = 1; vic_src = v.arg[ID_W-1:0]; vic_addr = v.addr[ADDR_W-1:0]; end
      E_CDAT: begin cdata_valid = 1; cdata_dirty = v.arg[0]; cdata = v.data[DATA_W-1:0]; end
      E_CCL:  begin ccl_valid = 1; ccl_src = v.arg[ID_W-1:0]; ccl_addr = v.addr[ADDR_W-1:0]; end
      E_RD:   begin rd_valid = 1; rd_addr = v.addr[ADDR_W-1:0]; end
      default: ;
    endcase
  endtask

  function automatic logic [14:0] obs_flags();
    return {dreq_valid, dreq_kind, wb_valid, wb_shared & wb_valid, wb_dirty & wb_valid,
            prsp_valid, prsp_kind, vic_ack, vic_retry, unblk, repl_retry, line_inval,
            ccl_retry};
  endfunction

  function automatic logic [14:0] exp_flags(input vec_t v);
    return {v.req[0], v.rk[1:0], v.wb[0], v.shr[0], v.dty[0], v.prsp[0], v.pk[1:0],
            v.ack[0], v.vrt[0], v.unb[0], v.rrt[0], v.inv[0], v.crt[0]};
  endfunction

  // apply at a falling edge, sample one full cycle later (one register in the path)
  task automatic apply(input vec_t v);
    logic [14:0]       a_f, e_f;
    logic [DATA_W-1:0] a_d;
    bit                bad;
    drive(v);
    @(negedge clk);
    clear_in();
    a_f = obs_flags();
    e_f = exp_flags(v);
    a_d = wb_valid ? wb_data : prsp_data;
    bad = (a_f != e_f);
    if ((v.wb != 0 || (v.prsp != 0 && v.pk == 2)) && a_d != v.edata[DATA_W-1:0]) bad = 1;
    if (v.req != 0 && dreq_addr != v.addr[ADDR_W-1:0]) bad = 1;
    if (v.ack != 0 && vic_dst != v.arg[ID_W-1:0]) bad = 1;
    n_vec++;
    if (bad) begin
      n_bad++;
      $display("FAIL R%0d vec %0d: flags=%b data=%h addr=%h dst=%0d expected flags=%b data=%h addr=%h",
               v.rid, n_vec, a_f, a_d, dreq_addr, vic_dst, e_f, v.edata[DATA_W-1:0],
               v.addr[ADDR_W-1:0]);
    end
  endtask

  function automatic vec_t mk(input int ev, input int arg, input int addr, input int data);
    vec_t v = '0;
    v.ev = ev; v.arg = arg; v.addr = addr; v.data = data;
    return v;
  endfunction

  initial begin
    vec_t v;
    clear_in();
    repeat (3) @(negedge clk);
    // reset state: every strobe low
    n_vec++;
    if (obs_flags() != '0) begin
      n_bad++;
      $display("FAIL R13 reset: flags=%b expected 0", obs_flags());
    end
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // reset in the middle of an eviction drops it (R2, R13)
    v = mk(E_REPL, 4, A, D0); v.req = 1; v.inv = 1; v.rid = 2;
    apply(v);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    v = mk(E_ACK, 0, 0, 0); v.rid = 13;
    apply(v);
    v = mk(E_RD, 0, A, 0); v.rid = 11;
    apply(v);
    // block is idle again: clean replace only invalidates (R1)
    v = mk(E_REPL, 2, B, 0); v.inv = 1; v.rid = 1;
    apply(v);
    // invalid-state replace does nothing (R1)
    v = mk(E_REPL, 0, B, D0); v.rid = 1;
    apply(v);
    // two downgrades keep the wait; shared flag on writeback (R6)
    v = mk(E_REPL, 3, B, D2); v.req = 1; v.inv = 1; v.rid = 2;
    apply(v);
    v = mk(E_PRB, 2, B, 0); v.prsp = 1; v.pk = 2; v.edata = D2; v.rid = 6;
    apply(v);
    v = mk(E_PRB, 2, B, 0); v.prsp = 1; v.pk = 2; v.edata = D2; v.rid = 6;
    apply(v);
    v = mk(E_ACK, 0, 0, 0); v.wb = 1; v.shr = 1; v.dty = 1; v.edata = D2; v.rid = 6;
    apply(v);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule